// File: doc/BRIEF.md
# Multiprocessor UART frame receiver

This block takes one asynchronous serial line and turns it into received bytes. The line is oversampled at 16 times the bit rate. Each sample slot is marked by an enable strobe that comes from outside, so the block generates no baud tick of its own. Two frame shapes can be selected. The short frame has a start bit, eight data bits and a stop bit. The long frame adds a ninth data bit between the data and the stop bit. Data arrives least significant bit first.

A falling edge on the line starts a frame. Three samples taken near the middle of each bit time are combined by a two-of-three vote. A start bit whose vote is not low is treated as noise. The receiver does not count bits to find the end of the frame. A shift register is filled with ones when the frame starts. The frame ends when the start bit's zero reaches the top of that register.

A finished frame is handed over only when the receive flag is clear. When multiprocessor filtering is on, the frame must also have its last sampled bit high. That bit is the ninth bit in the long frame and the stop bit in the short frame. Software clears the flag with a clear strobe.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, `rx_flag`, `data_o` and `bit9_o` are all 0.
- R2: With `frame11`=0, a frame of start(0), eight data bits sent LSB first and one further bit puts the byte on `data_o` and that further bit (the stop bit) on `bit9_o`, and sets `rx_flag`.
- R3: With `frame11`=1, the ninth bit (frame bit index 9, after the eight data bits) goes to `bit9_o` and the byte to `data_o`. The stop bit that follows is not stored.
- R4: Each bit is sampled at oversample counts 7, 8 and 9 after its start, and the value seen in at least two of the three samples is taken. A single inverted sample does not change the received byte.
- R5: A low pulse whose start-bit vote is 1 is discarded. No flag is set, and the next frame is received normally.
- R6: A frame that ends while `rx_flag` is 1 is discarded: `data_o`, `bit9_o` and `rx_flag` keep their values.
- R7: With `mp_en`=1, a frame whose last sampled bit (ninth bit with `frame11`=1, stop bit with `frame11`=0) is 0 is discarded, and one whose last sampled bit is 1 is accepted. With `mp_en`=0 that bit does not gate acceptance.
- R8: `flag_clr`=1 makes `rx_flag` 0 on the next cycle, even in the cycle a frame would set it. `rx_flag` falls only through `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| frame11 | input | 1 | 1 selects the 11-bit frame, 0 the 10-bit frame |
| mp_en | input | 1 | Multiprocessor filter enable |
| flag_clr | input | 1 | Clears the receive flag |
| data_o | output | 8 | Last accepted data byte |
| bit9_o | output | 1 | Last accepted ninth bit or stop bit |
| rx_flag | output | 1 | Receive flag |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as the final shift of an accepted frame. A late clear would hide the fault, so that cycle must be hit exactly. The bench drives the line on falling clock edges with the strobe held high. It works out the rising edge of the final shift from the two synchronizer stages, the edge-detect stage and the count of nine samples. It then pulses the clear only for that edge. After that it checks that the byte was loaded while the flag stayed low. Single-sample glitches are placed on one chosen vote slot in the same way.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_TAIL
   } rx_state_e;
endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpuart_rx_vote.sv
module mpuart_rx_vote (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic y_o
);
   assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick16,
   input  logic                 rxd,
   input  logic                 frame11,
   input  logic                 mp_en,
   input  logic                 flag_clr,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 bit9_o,
   output logic                 rx_flag
);
   import mpuart_rx_pkg::*;

   localparam int CW    = $clog2(OVERSAMPLE);
   localparam int SR_W  = DATA_BITS + 1;
   localparam int MID   = OVERSAMPLE / 2;
   localparam logic [CW-1:0] CNT_A    = CW'(MID - 1);
   localparam logic [CW-1:0] CNT_B    = CW'(MID);
   localparam logic [CW-1:0] CNT_C    = CW'(MID + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);

   if (OVERSAMPLE < 4)  begin : g_bad_ovs  $error("OVERSAMPLE must be at least 4"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   if (DATA_BITS < 1)   begin : g_bad_data $error("DATA_BITS must be at least 1"); end

   logic            rxd_s;
   logic            bit_v;
   rx_state_e       state_q;
   logic [CW-1:0]   cnt_q;
   logic [1:0]      smp_q;
   logic            prev_q;
   logic [SR_W-1:0] sh_q;
   logic [SR_W-1:0] sh_next;
   logic [DATA_BITS-1:0] byte_next;
   logic [DATA_BITS-1:0] data_q;
   logic            bit9_q;
   logic            flag_q;
   logic            at_vote;
   logic            fall_seen;
   logic            last_shift;
   logic            accept;

   mpuart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd),
      .q_o   (rxd_s)
   );

   mpuart_rx_vote u_vote (
      .a_i (smp_q[0]),
      .b_i (smp_q[1]),
      .c_i (rxd_s),
      .y_o (bit_v)
   );

   assign at_vote    = tick16 && (cnt_q == CNT_C) && (state_q != RX_IDLE);
   assign fall_seen  = tick16 && (state_q == RX_IDLE) && prev_q && !rxd_s;
   assign sh_next    = {sh_q[SR_W-2:0], bit_v};
   assign last_shift = at_vote && (state_q == RX_DATA) && !sh_q[SR_W-1];
   assign accept     = last_shift && !flag_q && (!mp_en || bit_v);

   // first data bit lands highest; reverse into LSB-first order
   for (genvar k = 0; k < DATA_BITS; k++) begin : g_rev
      assign byte_next[k] = sh_next[SR_W-1-k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         smp_q   <= '1;
         prev_q  <= 1'b1;
         sh_q    <= '1;
      end else if (tick16) begin
         prev_q <= rxd_s;
         if (cnt_q == CNT_A) smp_q[0] <= rxd_s;
         if (cnt_q == CNT_B) smp_q[1] <= rxd_s;
         if (state_q == RX_IDLE) begin
            if (fall_seen) begin
               state_q <= RX_START;
               cnt_q   <= CW'(1);
               sh_q    <= '1;
            end
         end else begin
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CW'(1);
            if (at_vote) begin
               unique case (state_q)
                  RX_START: begin
                     if (bit_v) state_q <= RX_IDLE;
                     else begin
                        sh_q    <= sh_next;
                        state_q <= RX_DATA;
                     end
                  end
                  RX_DATA: begin
                     if (last_shift) state_q <= frame11 ? RX_TAIL : RX_IDLE;
                     else            sh_q    <= sh_next;
                  end
                  RX_TAIL: state_q <= RX_IDLE;
                  default: state_q <= RX_IDLE;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         bit9_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (accept) begin
            data_q <= byte_next;
            bit9_q <= bit_v;
         end
         if (flag_clr)    flag_q <= 1'b0;
         else if (accept) flag_q <= 1'b1;
      end
   end

   assign data_o  = data_q;
   assign bit9_o  = bit9_q;
   assign rx_flag = flag_q;
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 flag_clr,
   input logic                 mp_en,
   input logic                 rx_flag,
   input logic [DATA_BITS-1:0] data_o,
   input logic                 bit9_o,
   input logic                 idle
);
   // R8
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !rx_flag);

   // R8
   fall_by_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_flag) |-> $past(flag_clr));

   // R6
   hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flag |=> ($stable(data_o) && $stable(bit9_o)));

   // R7
   mp_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_flag) && $past(mp_en)) |-> bit9_o);

   // R5
   no_idle_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> $past(!idle));
endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flag_clr (flag_clr),
   .mp_en    (mp_en),
   .rx_flag  (rx_flag),
   .data_o   (data_o),
   .bit9_o   (bit9_o),
   .idle     (state_q == mpuart_rx_pkg::RX_IDLE)
);

// File: tb/test_mpuart_rx.sv
`timescale 1ns/1ps
module test_mpuart_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic       rxd = 1'b1;
   logic       frame11 = 1'b0;
   logic       mp_en = 1'b0;
   logic       flag_clr = 1'b0;
   logic [7:0] data_o;
   logic       bit9_o;
   logic       rx_flag;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   mpuart_rx i_mpuart_rx (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .frame11(frame11), .mp_en(mp_en), .flag_clr(flag_clr),
      .data_o(data_o), .bit9_o(bit9_o), .rx_flag(rx_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drives one frame on falling edges; glitch inverts sample slot 8 of a bit,
   // clr_at pulses flag_clr on the given falling-edge index
   task automatic send(input logic [7:0] d, input logic nb, input logic eleven,
                       input int glitch, input int clr_at);
      logic [10:0] fr;
      int nbits;
      fr = {1'b1, nb, d, 1'b0};
      nbits = eleven ? 11 : 10;
      frame11 = eleven;
      for (int i = 0; i < nbits*16; i++) begin
         @(negedge clk);
         rxd = fr[i/16];
         if (glitch >= 0 && i == glitch*16 + 8) rxd = ~fr[i/16];
         flag_clr = (i == clr_at);
      end
      @(negedge clk);
      rxd = 1'b1;
      flag_clr = 1'b0;
      repeat (24) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 flag", rx_flag, 0);
      chk("R1 data", data_o, 0);
      chk("R1 bit9", bit9_o, 0);
   endtask

   task automatic t_frame10();
      send(8'hA5, 1'b1, 1'b0, -1, -1);
      chk("R2 data", data_o, 8'hA5);
      chk("R2 bit9", bit9_o, 1);
      chk("R2 flag", rx_flag, 1);
      clear_flag();
      chk("R8 cleared", rx_flag, 0);
      send(8'h3C, 1'b0, 1'b0, -1, -1);
      chk("R2 data stop0", data_o, 8'h3C);
      chk("R2 bit9 stop0", bit9_o, 0);
      clear_flag();
   endtask

   task automatic t_frame11();
      send(8'h81, 1'b0, 1'b1, -1, -1);
      chk("R3 data", data_o, 8'h81);
      chk("R3 ninth0", bit9_o, 0);
      chk("R3 flag", rx_flag, 1);
      clear_flag();
      send(8'h7E, 1'b1, 1'b1, -1, -1);
      chk("R3 data b", data_o, 8'h7E);
      chk("R3 ninth1", bit9_o, 1);
      clear_flag();
   endtask

   task automatic t_majority();
      send(8'h55, 1'b1, 1'b0, 4, -1);
      chk("R4 glitched data bit", data_o, 8'h55);
      clear_flag();
      send(8'h0F, 1'b1, 1'b1, 0, -1);
      chk("R4 glitched start", data_o, 8'h0F);
      chk("R4 flag", rx_flag, 1);
      clear_flag();
   endtask

   task automatic t_false_start();
      frame11 = 1'b0;
      @(negedge clk); rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
      chk("R5 no flag", rx_flag, 0);
      chk("R5 data kept", data_o, 8'h0F);
      send(8'hC3, 1'b1, 1'b0, -1, -1);
      chk("R5 next frame", data_o, 8'hC3);
      clear_flag();
   endtask

   task automatic t_busy();
      send(8'h12, 1'b1, 1'b0, -1, -1);
      send(8'hED, 1'b0, 1'b1, -1, -1);
      chk("R6 data kept", data_o, 8'h12);
      chk("R6 bit9 kept", bit9_o, 1);
      chk("R6 flag", rx_flag, 1);
      clear_flag();
   endtask

   task automatic t_mp();
      mp_en = 1'b1;
      send(8'h44, 1'b0, 1'b1, -1, -1);
      chk("R7 ninth0 dropped flag", rx_flag, 0);
      chk("R7 ninth0 dropped data", data_o, 8'h12);
      send(8'h99, 1'b1, 1'b1, -1, -1);
      chk("R7 ninth1 accepted", data_o, 8'h99);
      chk("R7 flag", rx_flag, 1);
      clear_flag();
      send(8'h66, 1'b0, 1'b0, -1, -1);
      chk("R7 stop0 dropped", rx_flag, 0);
      chk("R7 stop0 data", data_o, 8'h99);
      mp_en = 1'b0;
      send(8'h27, 1'b0, 1'b1, -1, -1);
      chk("R7 filter off", data_o, 8'h27);
      clear_flag();
   endtask

   task automatic t_clr_prio();
      // final shift at rising edge 155 after the line falls
      send(8'hB4, 1'b1, 1'b0, -1, 155);
      chk("R8 clear wins flag", rx_flag, 0);
      chk("R8 data loaded", data_o, 8'hB4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_frame10();
      t_frame11();
      t_majority();
      t_false_start();
      t_busy();
      t_mp();
      t_clr_prio();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule